// File: doc/BRIEF.md
# OTP Access and Lock Sequencer

This block sits on the host side of a byte-wide register bus to an attached sensor that holds a one-time-programmable (OTP) array. It turns two high-level commands into the multi-register handshake the sensor expects. A read command carries an 8-bit OTP address and returns the stored data byte. A lock command carries a lock level. The block runs the lock with status checking and a bounded number of retries, and it reports pass or fail.

Every bus access is a single write or read strobe that is held until the bus returns ready. Command bits that clear themselves are polled until they drop. A failed lock attempt waits a timed interval and then starts again from the OTP-enable step. After the last allowed attempt fails, the block raises a sticky defective-device flag. The wait length comes from a clock-frequency parameter, so a simulation can shorten it.

Top module: `otp_seq`

## Requirements
- R1: The first command after reset begins by writing 0x01 to register 0x42 (clock enable). Later commands, and lock retries, do not write 0x42 again.
- R2: Each command, and each lock retry, writes 0x01 to register 0x51 (OTP enable). This comes first, or right after the R1 write when that write occurs.
- R3: A read writes the OTP address to 0x52 and then 0x02 to 0x54. It then reads 0x54 until bit 1 reads 0 and then reads 0x53. It finishes with done_ok=1 and done_data equal to the byte read from 0x53.
- R4: A lock writes 0x04 (level 0) or 0x08 (level 1) to 0x54. It then reads 0x54 until that same bit reads 0, and then reads status register 0x58 once per attempt.
- R5: A lock attempt passes only when both flags of its own level are set in 0x58: bits 4 and 5 for level 0, bits 6 and 7 for level 1. The flags of the other level have no effect. A pass finishes with done_ok=1.
- R6: After a failed attempt that is not the last, the block waits at least WAIT_MS milliseconds of clock cycles (CLK_HZ/1000*WAIT_MS) before the next OTP-enable write.
- R7: When attempt number MAX_TRIES (10) fails, the block finishes with done_ok=0 and sets the defective output. Defective stays high until reset.
- R8: A bus strobe keeps its address and write data stable until the cycle in which bus_ready is seen. Write and read strobes are never high together.
- R9: Busy rises on command acceptance and stays high until done, and done is a one-cycle pulse. A command presented while busy is ignored and issues no bus access.
- R10: A synchronous reset returns the block to idle with strobes, busy, done and defective low. It clears the retry count and forgets that the clock enable was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, sampled while idle |
| cmd_lock | input | 1 | 0 = read command, 1 = lock command |
| cmd_level | input | 1 | Lock level (0 or 1) |
| cmd_addr | input | 8 | OTP address for a read |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | Pass (1) or fail (0), valid with done |
| done_data | output | 8 | Read result, valid with done after a read |
| defective | output | 1 | Sticky flag: all lock attempts failed |
| bus_addr | output | 8 | Register address on the sensor bus |
| bus_wdata | output | 8 | Register write data |
| bus_wr | output | 1 | Write strobe, held until ready |
| bus_rd | output | 1 | Read strobe, held until ready |
| bus_rdata | input | 8 | Register read data, valid with ready |
| bus_ready | input | 1 | Transfer complete |

## Verification
The embedded assertions check the cycle-level rules on every cycle. Strobes are exclusive and stay stable until ready. Any strobe implies busy. Done is a single pulse taken with busy low. The retry count never passes its bound, the wait counter stays in range, and defective stays set once raised. Only the bench scenarios can show the ordering of register accesses per command, the skipping of the clock-enable write after the first command, and the returned data over the full address range. The same holds for the pass/fail decision on same-level and other-level flags, the minimum wait between attempts, and the exact tenth-attempt failure boundary.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CLKEN, ST_OTPEN, ST_ADDR, ST_LAUNCH,
    ST_POLL, ST_DATA, ST_STAT, ST_WAIT
  } seq_state_t;

  localparam logic [7:0] REG_CLKEN = 8'h42;
  localparam logic [7:0] REG_CFG   = 8'h51;
  localparam logic [7:0] REG_ADDR  = 8'h52;
  localparam logic [7:0] REG_DATA  = 8'h53;
  localparam logic [7:0] REG_CTRL  = 8'h54;
  localparam logic [7:0] REG_STAT  = 8'h58;

  localparam logic [7:0] VAL_ON    = 8'h01;
  localparam logic [7:0] CTRL_RD   = 8'h02;
  localparam logic [7:0] CTRL_LK0  = 8'h04;
  localparam logic [7:0] CTRL_LK1  = 8'h08;
endpackage

// File: rtl/otp_bus_port.sv
module otp_bus_port #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_wr,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_wdata,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_wr,
  output logic          bus_rd,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready,
  output logic          ack,
  output logic [DW-1:0] ack_data
);
  logic active;
  assign active = bus_wr | bus_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_wr    <= 1'b0;
      bus_rd    <= 1'b0;
      ack       <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      ack_data  <= '0;
    end else begin
      ack <= 1'b0;
      if (active && bus_ready) begin
        bus_wr   <= 1'b0;
        bus_rd   <= 1'b0;
        ack      <= 1'b1;
        ack_data <= bus_rdata;
      end else if (start && !active) begin
        bus_wr    <= start_wr;
        bus_rd    <= !start_wr;
        bus_addr  <= start_addr;
        bus_wdata <= start_wdata;
      end
    end
  end

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_rd));

  // R8
  strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !bus_ready) |=> (active && $stable(bus_addr) && $stable(bus_wdata)
                                && $stable(bus_wr)));
endmodule

// File: rtl/otp_wait_timer.sv
module otp_wait_timer #(
  parameter int CYCLES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic expired
);
  localparam int W = $clog2(CYCLES + 1);
  localparam logic [W-1:0] LOAD = W'(CYCLES - 1);

  logic [W-1:0] cnt;
  logic         run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      run     <= 1'b0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (start) begin
        cnt <= LOAD;
        run <= 1'b1;
      end else if (run) begin
        if (cnt == '0) begin
          run     <= 1'b0;
          expired <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R6
  wait_range_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= LOAD));

  // R6
  expire_stop_chk: assert property (@(posedge clk) disable iff (rst)
    expired |-> !run);
endmodule

// File: rtl/otp_retry_ctr.sv
module otp_retry_ctr #(
  parameter int MAX = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       inc,
  output logic [$clog2(MAX+1)-1:0]   count,
  output logic                       last
);
  localparam int W = $clog2(MAX + 1);
  localparam logic [W-1:0] LAST_VAL = W'(MAX - 1);

  assign last = (count == LAST_VAL);

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + 1'b1;
  end

  // R7
  retry_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= LAST_VAL);

  // R7
  no_inc_at_last_chk: assert property (@(posedge clk) disable iff (rst)
    inc |-> !last);
endmodule

// File: rtl/otp_seq.sv
module otp_seq
  import otp_seq_pkg::*;
#(
  parameter int CLK_HZ    = 250_000_000,
  parameter int WAIT_MS   = 10,
  parameter int MAX_TRIES = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic       cmd_lock,
  input  logic       cmd_level,
  input  logic [7:0] cmd_addr,
  output logic       busy,
  output logic       done,
  output logic       done_ok,
  output logic [7:0] done_data,
  output logic       defective,
  output logic [7:0] bus_addr,
  output logic [7:0] bus_wdata,
  output logic       bus_wr,
  output logic       bus_rd,
  input  logic [7:0] bus_rdata,
  input  logic       bus_ready
);
  localparam int RAW_WAIT    = (CLK_HZ / 1000) * WAIT_MS;
  localparam int WAIT_CYCLES = (RAW_WAIT < 1) ? 1 : RAW_WAIT;
  localparam int TRY_W       = $clog2(MAX_TRIES + 1);

  seq_state_t state;
  logic       clk_on;
  logic       issued;
  logic       op_lock, op_level;
  logic [7:0] op_addr;

  logic       x_start, x_wr, ack;
  logic [7:0] x_addr, x_wdata, ack_data;
  logic       tmr_start, tmr_done;
  logic       try_clr, try_inc, try_last;
  logic [TRY_W-1:0] try_cnt;

  logic [7:0] cmd_bit;
  logic       lock_ok, crc_ok, stat_good;

  assign cmd_bit   = !op_lock ? CTRL_RD : (op_level ? CTRL_LK1 : CTRL_LK0);
  assign lock_ok   = op_level ? ack_data[6] : ack_data[4];
  assign crc_ok    = op_level ? ack_data[7] : ack_data[5];
  assign stat_good = lock_ok && crc_ok;

  always_comb begin
    x_wr    = 1'b0;
    x_addr  = REG_CFG;
    x_wdata = VAL_ON;
    unique case (state)
      ST_CLKEN:  begin x_wr = 1'b1; x_addr = REG_CLKEN; x_wdata = VAL_ON;  end
      ST_OTPEN:  begin x_wr = 1'b1; x_addr = REG_CFG;   x_wdata = VAL_ON;  end
      ST_ADDR:   begin x_wr = 1'b1; x_addr = REG_ADDR;  x_wdata = op_addr; end
      ST_LAUNCH: begin x_wr = 1'b1; x_addr = REG_CTRL;  x_wdata = cmd_bit; end
      ST_POLL:   begin x_addr = REG_CTRL; end
      ST_DATA:   begin x_addr = REG_DATA; end
      ST_STAT:   begin x_addr = REG_STAT; end
      default:   begin x_addr = REG_CFG; end
    endcase
  end

  assign x_start   = !issued && (state != ST_IDLE) && (state != ST_WAIT);
  assign try_clr   = (state == ST_IDLE) && cmd_valid;
  assign try_inc   = (state == ST_STAT) && ack && !stat_good && !try_last;
  assign tmr_start = try_inc;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      clk_on    <= 1'b0;
      issued    <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      done_ok   <= 1'b0;
      done_data <= '0;
      defective <= 1'b0;
      op_lock   <= 1'b0;
      op_level  <= 1'b0;
      op_addr   <= '0;
    end else begin
      done <= 1'b0;
      if (x_start)  issued <= 1'b1;
      else if (ack) issued <= 1'b0;

      unique case (state)
        ST_IDLE: if (cmd_valid) begin
          busy     <= 1'b1;
          op_lock  <= cmd_lock;
          op_level <= cmd_level;
          op_addr  <= cmd_addr;
          state    <= clk_on ? ST_OTPEN : ST_CLKEN;
        end
        ST_CLKEN: if (ack) begin
          clk_on <= 1'b1;
          state  <= ST_OTPEN;
        end
        ST_OTPEN:  if (ack) state <= op_lock ? ST_LAUNCH : ST_ADDR;
        ST_ADDR:   if (ack) state <= ST_LAUNCH;
        ST_LAUNCH: if (ack) state <= ST_POLL;
        ST_POLL: if (ack && ((ack_data & cmd_bit) == '0))
          state <= op_lock ? ST_STAT : ST_DATA;
        ST_DATA: if (ack) begin
          state     <= ST_IDLE;
          busy      <= 1'b0;
          done      <= 1'b1;
          done_ok   <= 1'b1;
          done_data <= ack_data;
        end
        ST_STAT: if (ack) begin
          if (stat_good || try_last) begin
            state     <= ST_IDLE;
            busy      <= 1'b0;
            done      <= 1'b1;
            done_ok   <= stat_good;
            done_data <= '0;
            if (!stat_good) defective <= 1'b1;
          end else begin
            state <= ST_WAIT;
          end
        end
        ST_WAIT: if (tmr_done) state <= ST_OTPEN;
        default: state <= ST_IDLE;
      endcase
    end
  end

  otp_bus_port #(.AW(8), .DW(8)) u_port (
    .clk(clk), .rst(rst),
    .start(x_start), .start_wr(x_wr), .start_addr(x_addr), .start_wdata(x_wdata),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .ack(ack), .ack_data(ack_data)
  );

  otp_wait_timer #(.CYCLES(WAIT_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(tmr_start), .expired(tmr_done)
  );

  otp_retry_ctr #(.MAX(MAX_TRIES)) u_retry (
    .clk(clk), .rst(rst), .clr(try_clr), .inc(try_inc),
    .count(try_cnt), .last(try_last)
  );

  // R9
  strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr || bus_rd) |-> busy);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R7
  defect_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    defective |=> defective);

  // R6
  wait_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> !(bus_wr || bus_rd));

  // R7
  retry_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OTPEN && !op_lock) |-> (try_cnt == '0));
endmodule

// File: tb/otp_seq_tb.sv
module otp_seq_tb;
  localparam int CLK_HZ = 2000;
  localparam int WAIT_MS = 10;
  localparam int WAITC = CLK_HZ / 1000 * WAIT_MS;
  localparam int LOGN = 8192;

  logic clk = 0, rst = 1;
  logic cmd_valid = 0, cmd_lock = 0, cmd_level = 0;
  logic [7:0] cmd_addr = 0;
  logic busy, done, done_ok, defective;
  logic [7:0] done_data, bus_addr, bus_wdata, bus_rdata;
  logic bus_wr, bus_rd, bus_ready;

  always #2 clk = ~clk;

  otp_seq #(.CLK_HZ(CLK_HZ), .WAIT_MS(WAIT_MS), .MAX_TRIES(10)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_lock(cmd_lock),
    .cmd_level(cmd_level), .cmd_addr(cmd_addr), .busy(busy), .done(done),
    .done_ok(done_ok), .done_data(done_data), .defective(defective),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready));

  int nchk = 0, nfail = 0, cyc = 0;
  int nlog = 0, lp = 0, lat = 0;
  int poll_n = 2, poll_left = 0, fail_left = 0, cur_level = 0;
  logic [7:0] r_ctrl = 0, r_addr = 0;
  logic log_wr [LOGN];
  logic [7:0] log_a [LOGN];
  logic [7:0] log_d [LOGN];
  int log_c [LOGN];

  always @(posedge clk) cyc <= cyc + 1;

  initial begin bus_ready = 0; bus_rdata = 0; end

  // Register-bus responder, acts between clock edges
  always @(negedge clk) begin
    if (bus_ready) bus_ready = 0;
    else if (bus_wr || bus_rd) begin
      if (lat > 0) lat--;
      else begin
        bus_ready = 1;
        if (nlog < LOGN) begin
          log_wr[nlog] = bus_wr; log_a[nlog] = bus_addr;
          log_d[nlog] = bus_wdata; log_c[nlog] = cyc;
        end
        if (bus_wr) begin
          if (bus_addr == 8'h52) r_addr = bus_wdata;
          if (bus_addr == 8'h54) begin r_ctrl = bus_wdata; poll_left = poll_n; end
        end else begin
          case (bus_addr)
            8'h54: if (poll_left > 0) begin bus_rdata = r_ctrl; poll_left--; end
                   else begin r_ctrl = 0; bus_rdata = 0; end
            8'h53: bus_rdata = 8'(r_addr * 7 + 3);
            8'h58: begin
              if (fail_left > 0) begin
                // wrong combination for own level, other level's flags set
                if (cur_level == 0) bus_rdata = (fail_left[0] ? 8'h10 : 8'h20) | 8'hC0;
                else                bus_rdata = (fail_left[0] ? 8'h40 : 8'h80) | 8'h30;
                fail_left--;
              end else bus_rdata = (cur_level == 0) ? 8'h30 : 8'hC0;
            end
            default: bus_rdata = 8'h00;
          endcase
        end
        nlog++;
        lat = nlog % 3;
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ex(bit wr, int a, int wd, string tag);
    int act, exp;
    exp = (int'(wr) << 16) | (a << 8) | (wr ? wd : 0);
    if (lp < nlog && lp < LOGN)
      act = (int'(log_wr[lp]) << 16) | (int'(log_a[lp]) << 8) | (log_wr[lp] ? int'(log_d[lp]) : 0);
    else act = -1;
    chk(act == exp, tag, act, exp);
    lp++;
  endtask

  task automatic run_cmd(bit lk, bit lv, logic [7:0] a);
    @(negedge clk);
    cmd_valid = 1; cmd_lock = lk; cmd_level = lv; cmd_addr = a;
    lp = nlog;
    @(negedge clk);
    cmd_valid = 0;
    while (!done) @(negedge clk);
  endtask

  task automatic do_read(logic [7:0] a, bit first, int pn);
    poll_n = pn;
    run_cmd(0, 0, a);
    chk(done_ok == 1, "R3 read ok", done_ok, 1);
    chk(done_data == 8'(a * 7 + 3), "R3 read data", done_data, 8'(a * 7 + 3));
    if (first) ex(1, 8'h42, 8'h01, "R1 clock enable");
    ex(1, 8'h51, 8'h01, "R2 otp enable");
    ex(1, 8'h52, a, "R3 address");
    ex(1, 8'h54, 8'h02, "R3 launch");
    for (int k = 0; k <= pn; k++) ex(0, 8'h54, 0, "R3 poll");
    ex(0, 8'h53, 0, "R3 data fetch");
    chk(lp == nlog, "R3 no extra access", nlog - lp, 0);
  endtask

  task automatic do_lock(bit lv, int nbad, bit first, int pn);
    int att;
    poll_n = pn; cur_level = lv; fail_left = nbad;
    run_cmd(1, lv, 8'h00);
    att = (nbad >= 10) ? 10 : nbad + 1;
    if (first) ex(1, 8'h42, 8'h01, "R1 clock enable");
    for (int t = 0; t < att; t++) begin
      if (t > 0 && lp < LOGN)
        chk(log_c[lp] - log_c[lp-1] >= WAITC, "R6 retry wait", log_c[lp] - log_c[lp-1], WAITC);
      ex(1, 8'h51, 8'h01, "R2 otp enable per attempt");
      ex(1, 8'h54, lv ? 8'h08 : 8'h04, "R4 lock launch");
      for (int k = 0; k <= pn; k++) ex(0, 8'h54, 0, "R4 lock poll");
      ex(0, 8'h58, 0, "R4 status read");
    end
    chk(lp == nlog, "R7 attempts bounded", nlog - lp, 0);
    chk(done_ok == (nbad < 10), "R5 lock verdict", done_ok, nbad < 10);
    chk(defective == (nbad >= 10), "R7 defective flag", defective, nbad >= 10);
    fail_left = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(!busy && !done && !bus_wr && !bus_rd && !defective, "R10 reset state",
        {busy, done, bus_wr, bus_rd, defective}, 0);
    rst = 0;
    do_read(8'h3C, 1, 2);
    do_read(8'h3D, 0, 0);
    // R9 busy ignore: second command during first
    poll_n = 3;
    @(negedge clk);
    cmd_valid = 1; cmd_lock = 0; cmd_addr = 8'h11; lp = nlog;
    @(negedge clk);
    cmd_valid = 1; cmd_lock = 1; cmd_addr = 8'h99;
    chk(busy == 1, "R9 busy after accept", busy, 1);
    @(negedge clk);
    cmd_valid = 0;
    while (!done) @(negedge clk);
    chk(done_data == 8'(8'h11 * 7 + 3), "R9 ignored command", done_data, 8'(8'h11 * 7 + 3));
    @(negedge clk);
    chk(!done && !busy, "R9 done one pulse", {done, busy}, 0);
    lp = nlog;
    repeat (40) @(negedge clk);
    chk(nlog == lp, "R9 no access after ignored command", nlog - lp, 0);
    // full address sweep
    for (int a = 0; a < 256; a++) do_read(8'(a), 0, a % 4);
    // locks: level 0 pass, level 1 after failures, boundary 9 and 10
    do_lock(0, 0, 0, 1);
    do_lock(1, 3, 0, 2);
    do_lock(0, 2, 0, 0);
    do_lock(1, 9, 0, 1);
    do_lock(0, 10, 0, 1);
    do_read(8'h5A, 0, 1);
    chk(defective == 1, "R7 defective sticky", defective, 1);
    // R10 reset clears flag and clock-enable memory
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    chk(!defective && !busy, "R10 reset clears", {defective, busy}, 0);
    do_read(8'hA7, 1, 2);
    do_lock(1, 10, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule